// File: doc/BRIEF.md
# Debug Breakpoint Hit Evaluator

This block decides, for a set of hardware breakpoint slots, which ones matched on the current check and produces the updated debug status word. Each slot has its own address register. It also has a type field and two enable bits, both held in a shared control word. An execute slot matches when its address equals the current instruction pointer. A write or read/write watch slot matches when the memory side reports a watch hit for that slot. The I/O type is not handled and never matches.

A check is presented as a single-cycle `chk_valid` beat that carries all operands. The evaluator never back-pressures: it accepts one check on every clock and has no ready output. One cycle after an accepted beat, the registered results appear. The new status word has its low hit bits replaced by the slot match vector and all other bits copied from the incoming status. A write strobe asks the owner of the status register to store that word. An exception pulse is raised when at least one enabled slot matched. A matching slot records its status bit even when it is disabled. A force input lets the word be written back when no enabled slot matched.

Top module: `dbgbp_eval`

## Requirements
- R1: While `rst_n` is low, `stat_out`, `stat_we` and `dbg_exc` are all zero.
- R2: A slot whose 2-bit type field (control bits 16+4n and 17+4n) is 0 (execute) matches when its address equals `cur_ip`, and sets status bit n. For this type, `watch_hit[n]` has no effect.
- R3: A slot whose type is 1 (write) or 3 (read/write) matches when `watch_hit[n]` is 1, and sets status bit n. For these types, address equality with `cur_ip` has no effect.
- R4: A slot of type 2 (I/O) never matches, even when its address equals `cur_ip` and `watch_hit[n]` is 1.
- R5: Status bits 3:0 of the output come only from the slot matches, and every higher bit of `stat_out` equals the same bit of `dbg_stat_in` from the accepted beat.
- R6: A matching slot whose enables are both 0 still sets its status bit, but it causes neither `dbg_exc` nor `stat_we`.
- R7: Slot n counts as enabled when control bit 2n or control bit 2n+1 is set. Either bit alone is enough.
- R8: `stat_we` is 1 in the cycle after an accepted beat if an enabled slot matched or `force_upd` was 1. Otherwise it is 0.
- R9: `dbg_exc` is a one-cycle pulse in the cycle after an accepted beat in which an enabled slot matched. `force_upd` alone never raises it.
- R10: In the cycle after a clock with `chk_valid` low, both strobes are 0 and `stat_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_valid | input | 1 | Check beat present; always accepted |
| bp_addr | input | 128 | Slot addresses, slot n at bits 32n+31:32n |
| dbg_ctrl | input | 32 | Control word: enables in bits 7:0, types from bit 16 |
| dbg_stat_in | input | 32 | Current status word |
| cur_ip | input | 32 | Current instruction pointer |
| watch_hit | input | 4 | Watch hit reported per slot |
| force_upd | input | 1 | Write status back even with no enabled match |
| stat_out | output | 32 | Updated status word |
| stat_we | output | 1 | Status write strobe |
| dbg_exc | output | 1 | Debug exception request pulse |

## Verification
The only state in the block is the result register, so a wrong value shows at the ports in the cycle right after the beat that produced it. The bench therefore compares all three outputs on every clock. A swapped type decode or a misplaced enable bit shows up as a wrong status bit or a missing strobe on the first directed beat for that slot. A leak into the upper status bits shows up on the first beat whose incoming status has those bits set. A hold fault shows up on the first idle cycle, as a changed word or a stray strobe.

// File: rtl/dbgbp_pkg.sv
package dbgbp_pkg;
  typedef enum logic [1:0] {
    BPT_EXEC  = 2'b00,
    BPT_WRITE = 2'b01,
    BPT_IO    = 2'b10,
    BPT_RDWR  = 2'b11
  } bp_type_e;

  localparam int TYPE_BASE   = 16;
  localparam int TYPE_STRIDE = 4;
  localparam int EN_STRIDE   = 2;
endpackage

// File: rtl/dbgbp_slot.sv
module dbgbp_slot
  import dbgbp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic [ADDR_W-1:0] cur_ip,
  input  bp_type_e          slot_type,
  input  logic [1:0]        slot_en_bits,
  input  logic              slot_watch,
  output logic              slot_hit,
  output logic              slot_en
);
  always_comb begin
    unique case (slot_type)
      BPT_EXEC:  slot_hit = (slot_addr == cur_ip);
      BPT_WRITE,
      BPT_RDWR:  slot_hit = slot_watch;
      default:   slot_hit = 1'b0;
    endcase
  end

  assign slot_en = |slot_en_bits;
endmodule

// File: rtl/dbgbp_merge.sv
module dbgbp_merge #(
  parameter int NUM_SLOTS = 4,
  parameter int STAT_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chk_valid,
  input  logic [NUM_SLOTS-1:0] hit_vec,
  input  logic [NUM_SLOTS-1:0] en_vec,
  input  logic [STAT_W-1:0]    stat_in,
  input  logic                 force_upd,
  output logic [STAT_W-1:0]    stat_out,
  output logic                 stat_we,
  output logic                 dbg_exc
);
  localparam int KEEP_W = STAT_W - NUM_SLOTS;

  logic              any_en_hit;
  logic [STAT_W-1:0] stat_next;

  assign any_en_hit = |(hit_vec & en_vec);
  assign stat_next  = {stat_in[STAT_W-1:NUM_SLOTS], hit_vec};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_out <= '0;
      stat_we  <= 1'b0;
      dbg_exc  <= 1'b0;
    end else begin
      stat_we <= chk_valid & (any_en_hit | force_upd);
      dbg_exc <= chk_valid & any_en_hit;
      if (chk_valid) stat_out <= stat_next;
    end
  end

  // R9: an exception request always comes with a write strobe
  p_exc_with_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc |-> stat_we);

  // R10: no strobe without an accepted beat one cycle earlier
  p_we_needs_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> $past(chk_valid));

  // R10: idle cycle keeps the status word
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> $stable(stat_out));

  // R5: upper status bits follow the incoming word
  p_upper_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> stat_out[STAT_W-1:NUM_SLOTS] == $past(stat_in[STAT_W-1:NUM_SLOTS]));

  // R6: a disabled match alone never raises the exception
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && ((hit_vec & en_vec) == '0)) |=> !dbg_exc);

  initial assert (KEEP_W > 0) else $error("status word too narrow");
endmodule

// File: rtl/dbgbp_eval.sv
module dbgbp_eval
  import dbgbp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int CTRL_W    = 32,
  parameter int STAT_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        chk_valid,
  input  logic [NUM_SLOTS*ADDR_W-1:0] bp_addr,
  input  logic [CTRL_W-1:0]           dbg_ctrl,
  input  logic [STAT_W-1:0]           dbg_stat_in,
  input  logic [ADDR_W-1:0]           cur_ip,
  input  logic [NUM_SLOTS-1:0]        watch_hit,
  input  logic                        force_upd,
  output logic [STAT_W-1:0]           stat_out,
  output logic                        stat_we,
  output logic                        dbg_exc
);
  localparam int TYPE_TOP = TYPE_BASE + TYPE_STRIDE * NUM_SLOTS;

  logic [NUM_SLOTS-1:0] hit_vec;
  logic [NUM_SLOTS-1:0] en_vec;
  logic                 unused_ctrl;

  assign unused_ctrl = ^dbg_ctrl;

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    dbgbp_slot #(.ADDR_W(ADDR_W)) i_slot (
      .slot_addr    (bp_addr[n*ADDR_W +: ADDR_W]),
      .cur_ip       (cur_ip),
      .slot_type    (bp_type_e'(dbg_ctrl[TYPE_BASE + TYPE_STRIDE*n +: 2])),
      .slot_en_bits (dbg_ctrl[EN_STRIDE*n +: 2]),
      .slot_watch   (watch_hit[n]),
      .slot_hit     (hit_vec[n]),
      .slot_en      (en_vec[n])
    );

    // R4: an I/O-type slot never reports a match
    p_io_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && dbg_ctrl[TYPE_BASE + TYPE_STRIDE*n +: 2] == 2'b10) |=> !stat_out[n]);
  end

  dbgbp_merge #(.NUM_SLOTS(NUM_SLOTS), .STAT_W(STAT_W)) i_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (chk_valid),
    .hit_vec   (hit_vec),
    .en_vec    (en_vec),
    .stat_in   (dbg_stat_in),
    .force_upd (force_upd),
    .stat_out  (stat_out),
    .stat_we   (stat_we),
    .dbg_exc   (dbg_exc)
  );

  initial assert (TYPE_TOP <= CTRL_W) else $error("control word too narrow");
endmodule

// File: tb/test_dbgbp_eval.sv
module test_dbgbp_eval;
  localparam int NS = 4;
  localparam int AW = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              chk_valid = 1'b0;
  logic [NS*AW-1:0]  bp_addr = '0;
  logic [31:0]       dbg_ctrl = '0;
  logic [31:0]       dbg_stat_in = '0;
  logic [31:0]       cur_ip = '0;
  logic [NS-1:0]     watch_hit = '0;
  logic              force_upd = 1'b0;
  logic [31:0]       stat_out;
  logic              stat_we;
  logic              dbg_exc;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] exp_stat = '0;
  logic        exp_we = 1'b0;
  logic        exp_exc = 1'b0;
  string       exp_tag = "R1";
  bit          pending = 0;

  always #2 clk = ~clk;

  dbgbp_eval i_dbgbp_eval (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .bp_addr(bp_addr),
    .dbg_ctrl(dbg_ctrl), .dbg_stat_in(dbg_stat_in), .cur_ip(cur_ip),
    .watch_hit(watch_hit), .force_upd(force_upd),
    .stat_out(stat_out), .stat_we(stat_we), .dbg_exc(dbg_exc)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_now();
    if (pending) begin
      chk(exp_tag, "stat_out", stat_out, exp_stat);
      chk(exp_tag, "stat_we", {31'b0, stat_we}, {31'b0, exp_we});
      chk(exp_tag, "dbg_exc", {31'b0, dbg_exc}, {31'b0, exp_exc});
    end
  endtask

  // behavioural reference for one beat
  task automatic model();
    logic [NS-1:0] hits;
    bit any_en;
    hits = '0;
    any_en = 0;
    for (int i = 0; i < NS; i++) begin
      int t;
      bit en;
      t = int'(dbg_ctrl[16 + 4*i +: 2]);
      en = dbg_ctrl[2*i] || dbg_ctrl[2*i + 1];
      if ((t == 0 && bp_addr[i*AW +: AW] == cur_ip) ||
          ((t == 1 || t == 3) && watch_hit[i]))
        hits[i] = 1'b1;
      if (hits[i] && en) any_en = 1;
    end
    if (chk_valid) begin
      exp_stat = {dbg_stat_in[31:4], hits};
      exp_we   = any_en || force_upd;
      exp_exc  = any_en;
    end else begin
      exp_we  = 1'b0;
      exp_exc = 1'b0;
    end
  endtask

  task automatic beat(string tag, bit v, logic [NS*AW-1:0] a, logic [31:0] c,
                      logic [31:0] s, logic [31:0] ip, logic [NS-1:0] w, bit f);
    @(negedge clk);
    compare_now();
    chk_valid = v; bp_addr = a; dbg_ctrl = c; dbg_stat_in = s;
    cur_ip = ip; watch_hit = w; force_upd = f;
    exp_tag = tag;
    model();
    pending = 1;
  endtask

  localparam logic [NS*AW-1:0] ADDRS = {32'h4000_0000, 32'h3000_0000, 32'h2000_0000, 32'h1000_0000};

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "stat_out", stat_out, 32'h0);
    chk("R1", "stat_we", {31'b0, stat_we}, 32'h0);
    chk("R1", "dbg_exc", {31'b0, dbg_exc}, 32'h0);
    rst_n = 1'b1;
    // R2: execute type on slot 2, enabled via bit 4
    beat("R2", 1, ADDRS, 32'h0000_0010, 32'h0, 32'h3000_0000, 4'b0000, 0);
    // R2: watch flag ignored for execute type
    beat("R2", 1, ADDRS, 32'h0000_00FF, 32'h0, 32'h9999_0000, 4'b1111, 0);
    // R3: write type on slot 1, enabled via bit 3 (R7 odd bit)
    beat("R3", 1, ADDRS, 32'h0010_0008, 32'h0, 32'h9999_0000, 4'b0010, 0);
    // R3: read/write type on slot 3, address match ignored
    beat("R3", 1, ADDRS, 32'h3000_0040, 32'h0, 32'h4000_0000, 4'b0000, 0);
    beat("R3", 1, ADDRS, 32'h3000_0040, 32'h0, 32'h4000_0000, 4'b1000, 0);
    // R4: I/O type on all slots, address and watch both asserted
    beat("R4", 1, {4{32'h1000_0000}}, 32'hAAAA_00FF, 32'h0, 32'h1000_0000, 4'b1111, 0);
    // R5: upper status bits kept, low bits replaced
    beat("R5", 1, ADDRS, 32'h0000_0001, 32'hDEAD_BEEF, 32'h1000_0000, 4'b0000, 0);
    beat("R5", 1, ADDRS, 32'h0000_0000, 32'h1234_567F, 32'h5555_0000, 4'b0000, 0);
    // R6: disabled match records bit, no strobes
    beat("R6", 1, ADDRS, 32'h0000_0000, 32'h0, 32'h2000_0000, 4'b0000, 0);
    // R7: even enable bit alone
    beat("R7", 1, ADDRS, 32'h0000_0040, 32'h0, 32'h4000_0000, 4'b0000, 0);
    // R7: enable of another slot does not count
    beat("R7", 1, ADDRS, 32'h0000_00C0, 32'h0, 32'h1000_0000, 4'b0000, 0);
    // R8: force with no match writes, R9 no exception
    beat("R8", 1, ADDRS, 32'h0000_0000, 32'hF000_0000, 32'h0, 4'b0000, 1);
    beat("R9", 1, ADDRS, 32'h0000_0000, 32'h0, 32'h1000_0000, 4'b0000, 1);
    // R10: idle beats hold status even with matching operands
    beat("R10", 0, ADDRS, 32'h0000_00FF, 32'hFFFF_FFFF, 32'h1000_0000, 4'b1111, 1);
    beat("R10", 0, ADDRS, 32'h0000_00FF, 32'h0, 32'h0, 4'b0000, 0);
    // R9: back-to-back hits then idle gives pulses that end
    beat("R9", 1, ADDRS, 32'h0000_0003, 32'h0, 32'h1000_0000, 4'b0000, 0);
    beat("R9", 1, ADDRS, 32'h0000_0003, 32'h0, 32'h1000_0000, 4'b0000, 0);
    beat("R9", 0, ADDRS, 32'h0000_0003, 32'h0, 32'h1000_0000, 4'b0000, 0);
    // mixed: all four slots, different types
    beat("R3", 1, ADDRS, 32'h3102_0055, 32'h8000_0000, 32'h1000_0000, 4'b1110, 0);
    for (int k = 0; k < 24; k++)
      beat("R8", (k % 3) != 0, ADDRS ^ {4{32'(k)}}, 32'h0000_0000 | 32'(k * 32'h1111_0013),
           32'(k * 32'h0101_0101), 32'h1000_0000 ^ 32'(k), 4'(k), (k % 5) == 0);
    beat("R10", 0, ADDRS, 32'h0, 32'h0, 32'h0, 4'b0000, 0);
    @(negedge clk);
    compare_now();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule